// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a simple host request port and a 16-bit extended-data-out DRAM whose 20-bit word address is multiplexed as a 10-bit row followed by a 10-bit column. Each accepted host request becomes a sequence of row strobe, column strobe, write-enable and output-enable edges. Every minimum time is counted in controller clock cycles and set by a parameter.

After an access the row is left open. A later request to the same row needs only a new column strobe. A request to a different row first closes and precharges the bank, then opens the new row. The row is also closed before the row-active time reaches its upper limit. Writes drive the upper and lower byte strobes separately, so the host can write one byte or both.

A separate refresh and power-up block asks for the DRAM through a request line. This controller finishes the access in flight, closes the row at the next legal point, and grants the bus with every strobe held inactive.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, all strobes are high (inactive), `dram_dq_oe` is 0, and `rd_valid` and `refresh_gnt` are 0.
- R2: At the falling edge of `dram_ras_n`, `dram_addr` carries `req_addr[19:10]`. At each falling edge of a column strobe, `dram_addr` carries `req_addr[9:0]`. A column strobe falls only while `dram_ras_n` is low.
- R3: A read lowers both column strobes and `dram_oe_n` while `dram_we_n` stays high. Exactly RD_LAT cycles after the column strobes fall, `rd_valid` pulses for one cycle with `rd_data` equal to the word on `dram_dq_in`.
- R4: A write lowers `dram_we_n` and drives `dram_dq_out` with `dram_dq_oe` = 1 at least one cycle before its column strobes fall (early write). These hold while the strobes are low.
- R5: On a write, `req_be[1]` enables `dram_ucas_n` (data bits 15:8) and `req_be[0]` enables `dram_lcas_n` (bits 7:0). A byte whose enable is 0 keeps its stored value.
- R6: A request to the row that is already open is served with column strobes only, with no new row-strobe pulse.
- R7: A request to a different row closes the open row, precharges, and activates the new row. Data in the previous row is kept.
- R8: A column strobe falls no sooner than T_RCD cycles after `dram_ras_n` falls.
- R9: `dram_ras_n` stays low for at least T_RAS cycles and stays high for at least T_RP cycles before it falls again.
- R10: A column strobe stays low for at least T_CAS cycles. Between page cycles of one row it stays high for at least T_CP cycles.
- R11: `dram_ras_n` is never low for more than T_RAS_MAX cycles. A stream of hits to one row is split by forced closes.
- R12: While `refresh_req` is 1, `req_ready` is 0. The controller closes the open row after the legal minimum, then raises `refresh_gnt` with every strobe high. It holds these while `refresh_req` stays 1, and drops `refresh_gnt` in the cycle after `refresh_req` falls.
- R13: A request is taken in the cycle where `req_valid` and `req_ready` are both 1. Only one request is in flight, and every accepted read yields exactly one `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in 19:10, column in 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Write byte enables: bit 1 = upper byte, bit 0 = lower byte |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read data |
| rd_data | output | 16 | Read data |
| refresh_req | input | 1 | Refresh block asks for the DRAM |
| refresh_gnt | output | 1 | DRAM idle and precharged, handed over |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | 1 = controller drives the data bus |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The bench attaches a cycle-level DRAM model that latches the row and column on strobe edges and writes per byte lane. It drives random reads and writes spread over a few rows, so page hits and misses interleave. A long run of hits to one row must produce extra row activations. A design without the row-time limit would hold the row strobe low forever and break the upper bound.

Single-byte writes with one byte of a word set and the other byte untouched catch crossed or merged byte strobes, which corrupt the untouched byte. A refresh request raised while a row is open must close the row and keep the grant with all strobes inactive. A design that grants early would show the row strobe low during the grant.

Strobe spacing is measured on every edge: row-to-column delay, row low and high widths, and column widths. Read data is checked at the exact latency. A capture one cycle off returns a stale word.

// File: rtl/edo_pkg.sv
// Shared types for the EDO page-mode controller.
package edo_pkg;

    // Sequencer states. Row strobe low in ROW..CLOSE except PRE/IDLE/GNT.
    typedef enum logic [3:0] {
        S_PRE,    // row strobe high, counting precharge
        S_IDLE,   // precharged, no row open
        S_ROW,    // row address on the bus, row strobe about to fall
        S_ACT,    // row strobe low, waiting row-to-column delay
        S_CSET,   // column address set up, column strobes about to fall
        S_CLO,    // column strobes low
        S_CHI,    // column strobes high, column precharge
        S_OPEN,   // row open, waiting for the next request
        S_CLOSE,  // waiting for minimum row time, then raise row strobe
        S_GNT     // bus granted to the refresh block
    } seq_state_e;

endpackage

// File: rtl/edo_ras_timer.sv
// Row-strobe timer: counts the cycles the row strobe has been low and high.
// Reports when the minimum active time is met and when the row nears its
// maximum active time. Assumes ras_n is the registered strobe driven to the
// DRAM.
module edo_ras_timer #(
    parameter int T_RAS     = 6,
    parameter int T_RP      = 4,
    parameter int T_RAS_MAX = 1000,
    parameter int GUARD     = 8,
    localparam int LW = $clog2(T_RAS_MAX + 1),
    localparam int HW = $clog2(T_RP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    output logic [LW-1:0] lo_cnt,
    output logic          ras_min_met,
    output logic          near_max
);

    logic [HW-1:0] hi_cnt;

    // Count cycles since the row strobe fell; saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lo_cnt <= '0;
        else if (ras_n)                     lo_cnt <= '0;
        else if (lo_cnt != LW'(T_RAS_MAX))  lo_cnt <= lo_cnt + 1'b1;
    end

    // Count cycles since the row strobe rose; saturate at the precharge time.
    always_ff @(posedge clk) begin
        if (!rst_n)                    hi_cnt <= '0;
        else if (!ras_n)               hi_cnt <= '0;
        else if (hi_cnt != HW'(T_RP))  hi_cnt <= hi_cnt + 1'b1;
    end

    assign ras_min_met = (lo_cnt >= LW'(T_RAS - 1));
    assign near_max    = (lo_cnt >= LW'(T_RAS_MAX - GUARD));

    AST_RAS_UPPER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> lo_cnt < LW'(T_RAS_MAX)); // R11
    AST_RAS_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $past(lo_cnt) >= LW'(T_RAS - 1)); // R9
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(hi_cnt) >= HW'(T_RP - 1)); // R9

endmodule

// File: rtl/edo_row_track.sv
// Open-row tracker: remembers which row is active and flags page hits.
// Assumes load and close are never asserted in the same cycle.
module edo_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic             close,
    input  logic [ROW_W-1:0] query_row,
    output logic             hit,
    output logic             row_valid
);

    logic [ROW_W-1:0] open_row;

    // Record the row on activation, clear validity on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row  <= '0;
            row_valid <= 1'b0;
        end else if (load) begin
            open_row  <= load_row;
            row_valid <= 1'b1;
        end else if (close) begin
            row_valid <= 1'b0;
        end
    end

    // A hit needs an open row with a matching address.
    assign hit = row_valid && (open_row == query_row);

endmodule

// File: rtl/edo_seq.sv
// Strobe sequencer: the state machine that turns host requests into row,
// column, write-enable and output-enable edges, captures read data and
// hands the bus to the refresh block. Assumes 2 <= RD_LAT <= T_CAS and
// that the row timer's guard covers one full page cycle.
module edo_seq
    import edo_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    parameter int DW     = 16,
    parameter int T_RCD  = 2,
    parameter int T_RP   = 4,
    parameter int T_CAS  = 3,
    parameter int T_CP   = 1,
    parameter int RD_LAT = 2,
    localparam int BW = DW / 8,
    localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int CW = $clog2(T_RP + T_RCD + T_CAS + T_CP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [DW-1:0]    req_wdata,
    input  logic [BW-1:0]    req_be,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    input  logic             refresh_req,
    output logic             refresh_gnt,
    input  logic             near_max,
    input  logic             ras_min_met,
    input  logic             row_hit,
    output logic             row_load,
    output logic [ROW_W-1:0] row_load_val,
    output logic             row_close,
    output logic             ras_n,
    output logic [BW-1:0]    cas_n,
    output logic             we_n,
    output logic             oe_n,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    input  logic [DW-1:0]    dq_in
);

    seq_state_e       st;
    logic [CW-1:0]    cnt;
    logic             pend;
    logic             cur_wr;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic [DW-1:0]    cur_wdata;
    logic [BW-1:0]    cur_be;
    logic [BW-1:0]    lane_on;
    logic             accept;

    // Host can hand over a request when idle or in an open row with time left.
    assign req_ready = !refresh_req &&
                       ((st == S_IDLE && !pend) || (st == S_OPEN && !near_max));
    assign accept    = req_valid && req_ready;

    // Tracker strobes: load when the row strobe falls, clear when it rises.
    assign row_load     = (st == S_ROW);
    assign row_load_val = cur_row;
    assign row_close    = (st == S_CLOSE) && ras_min_met;

    // Per byte lane: reads use every lane, writes only the enabled ones.
    for (genvar b = 0; b < BW; b++) begin : g_lane
        assign lane_on[b] = !cur_wr || cur_be[b];
    end

    // Main sequencing: state, counters and all registered DRAM outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_PRE;
            cnt         <= '0;
            pend        <= 1'b0;
            cur_wr      <= 1'b0;
            cur_row     <= '0;
            cur_col     <= '0;
            cur_wdata   <= '0;
            cur_be      <= '0;
            ras_n       <= 1'b1;
            cas_n       <= '1;
            we_n        <= 1'b1;
            oe_n        <= 1'b1;
            addr        <= '0;
            dq_out      <= '0;
            dq_oe       <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            refresh_gnt <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                cur_wr    <= req_write;
                cur_row   <= req_row;
                cur_col   <= req_col;
                cur_wdata <= req_wdata;
                cur_be    <= req_be;
            end
            case (st)
                S_PRE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(T_RP - 1)) begin
                        cnt <= '0;
                        st  <= S_IDLE;
                    end
                end
                S_IDLE: begin
                    if (pend) begin
                        pend <= 1'b0;
                        addr <= AW'(cur_row);
                        st   <= S_ROW;
                    end else if (refresh_req) begin
                        refresh_gnt <= 1'b1;
                        st          <= S_GNT;
                    end else if (accept) begin
                        addr <= AW'(req_row);
                        st   <= S_ROW;
                    end
                end
                S_ROW: begin
                    ras_n <= 1'b0;
                    cnt   <= '0;
                    st    <= S_ACT;
                end
                S_ACT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(T_RCD - 1)) begin
                        addr   <= AW'(cur_col);
                        we_n   <= !cur_wr;
                        dq_oe  <= cur_wr;
                        dq_out <= cur_wdata;
                        st     <= S_CSET;
                    end
                end
                S_CSET: begin
                    cas_n <= ~lane_on;
                    oe_n  <= cur_wr;
                    cnt   <= '0;
                    st    <= S_CLO;
                end
                S_CLO: begin
                    cnt <= cnt + 1'b1;
                    if (!cur_wr && cnt == CW'(RD_LAT - 1)) begin
                        rd_data  <= dq_in;
                        rd_valid <= 1'b1;
                    end
                    if (cnt == CW'(T_CAS - 1)) begin
                        cas_n <= '1;
                        we_n  <= 1'b1;
                        oe_n  <= 1'b1;
                        dq_oe <= 1'b0;
                        cnt   <= '0;
                        st    <= S_CHI;
                    end
                end
                S_CHI: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(T_CP - 1)) begin
                        cnt <= '0;
                        st  <= S_OPEN;
                    end
                end
                S_OPEN: begin
                    if (accept) begin
                        if (row_hit) begin
                            addr   <= AW'(req_col);
                            we_n   <= !req_write;
                            dq_oe  <= req_write;
                            dq_out <= req_wdata;
                            st     <= S_CSET;
                        end else begin
                            pend <= 1'b1;
                            st   <= S_CLOSE;
                        end
                    end else if (refresh_req || near_max) begin
                        st <= S_CLOSE;
                    end
                end
                S_CLOSE: begin
                    if (ras_min_met) begin
                        ras_n <= 1'b1;
                        cnt   <= '0;
                        st    <= S_PRE;
                    end
                end
                S_GNT: begin
                    if (!refresh_req) begin
                        refresh_gnt <= 1'b0;
                        cnt         <= '0;
                        st          <= S_PRE;
                    end
                end
                default: st <= S_PRE;
            endcase
        end
    end

    AST_READ_KEEPS_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n); // R3
    AST_RDV_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R3
    AST_NO_ACCEPT_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> !req_ready); // R12

endmodule

// File: rtl/edo_page_ctrl.sv
// EDO DRAM page-mode controller top. Splits the host word address into row
// and column, wires the sequencer to the row tracker and the row-strobe
// timer, and maps the byte lanes to the upper and lower column strobes.
// Assumes a 16-bit DRAM with one row strobe and two byte column strobes.
module edo_page_ctrl #(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DW        = 16,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 4,
    parameter int T_RAS     = 6,
    parameter int T_CAS     = 3,
    parameter int T_CP      = 1,
    parameter int RD_LAT    = 2,
    parameter int T_RAS_MAX = 1000,
    localparam int AW    = ROW_W + COL_W,
    localparam int BW    = DW / 8,
    localparam int DA    = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int GUARD = T_CAS + T_CP + 4,
    localparam int LW    = $clog2(T_RAS_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [BW-1:0] req_be,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          refresh_req,
    output logic          refresh_gnt,
    output logic          dram_ras_n,
    output logic          dram_ucas_n,
    output logic          dram_lcas_n,
    output logic          dram_we_n,
    output logic          dram_oe_n,
    output logic [DA-1:0] dram_addr,
    output logic [DW-1:0] dram_dq_out,
    output logic          dram_dq_oe,
    input  logic [DW-1:0] dram_dq_in
);

    logic [ROW_W-1:0] q_row;
    logic [COL_W-1:0] q_col;
    logic             hit, row_valid, near_max, ras_min_met;
    logic             row_load, row_close;
    logic [ROW_W-1:0] row_load_val;
    logic [BW-1:0]    cas_n;
    logic [LW-1:0]    lo_cnt;
    logic             cas_any;

    // Row in the upper address bits, column in the lower ones.
    assign q_row = req_addr[AW-1:COL_W];
    assign q_col = req_addr[COL_W-1:0];

    edo_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .load(row_load), .load_row(row_load_val), .close(row_close),
        .query_row(q_row), .hit(hit), .row_valid(row_valid)
    );

    edo_ras_timer #(.T_RAS(T_RAS), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX),
                    .GUARD(GUARD)) u_timer (
        .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n),
        .lo_cnt(lo_cnt), .ras_min_met(ras_min_met), .near_max(near_max)
    );

    edo_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD),
              .T_RP(T_RP), .T_CAS(T_CAS), .T_CP(T_CP),
              .RD_LAT(RD_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(q_row), .req_col(q_col), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .refresh_req(refresh_req), .refresh_gnt(refresh_gnt),
        .near_max(near_max), .ras_min_met(ras_min_met), .row_hit(hit),
        .row_load(row_load), .row_load_val(row_load_val),
        .row_close(row_close), .ras_n(dram_ras_n), .cas_n(cas_n),
        .we_n(dram_we_n), .oe_n(dram_oe_n), .addr(dram_addr),
        .dq_out(dram_dq_out), .dq_oe(dram_dq_oe), .dq_in(dram_dq_in)
    );

    // Lane 1 is the upper byte, lane 0 the lower byte.
    assign dram_ucas_n = cas_n[1];
    assign dram_lcas_n = cas_n[0];
    assign cas_any     = !(dram_ucas_n && dram_lcas_n);

    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        cas_any |-> !dram_ras_n); // R2
    AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_any) |-> $past(lo_cnt) >= LW'(T_RCD - 1)); // R8
    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_any) && !dram_we_n) |-> ($past(!dram_we_n) && $past(dram_dq_oe))); // R4
    AST_TRACKER_MATCHES_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid == !dram_ras_n); // R6
    AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_gnt |-> (dram_ras_n && !cas_any && !dram_dq_oe)); // R12

endmodule

// File: tb/tb_edo_page_ctrl.sv
// Bench for edo_page_ctrl: cycle-level DRAM model, random plus directed
// traffic, and strobe-timing monitors sampled on the falling clock edge.
module tb_edo_page_ctrl;

    localparam int T_RCD = 2, T_RP = 4, T_RAS = 6, T_CAS = 3, T_CP = 1;
    localparam int RD_LAT = 2, T_RAS_MAX = 1000;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0, refresh_req = 0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rd_valid, refresh_gnt;
    logic [15:0] rd_data;
    logic        ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
    logic [9:0]  daddr;
    logic [15:0] dq_out, dq_in;

    int checks = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    edo_page_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .refresh_req(refresh_req), .refresh_gnt(refresh_gnt),
        .dram_ras_n(ras_n), .dram_ucas_n(ucas_n), .dram_lcas_n(lcas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(daddr),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [15:0] dmem [int];
    logic [9:0]  m_row = '0;
    logic [15:0] m_rdata = '0;
    logic        m_ras_q = 1, m_u_q = 1, m_l_q = 1;

    function automatic logic [15:0] dread(input int k);
        return dmem.exists(k) ? dmem[k] : 16'h0;
    endfunction

    always @(posedge clk) begin
        int k;
        logic [15:0] v;
        if (m_ras_q && !ras_n) m_row <= daddr;
        if (!ras_n && ((m_u_q && !ucas_n) || (m_l_q && !lcas_n))) begin
            k = int'({m_row, daddr});
            v = dread(k);
            m_rdata <= v;
            if (!we_n) begin
                if (m_u_q && !ucas_n) v[15:8] = dq_out[15:8];
                if (m_l_q && !lcas_n) v[7:0]  = dq_out[7:0];
                dmem[k] = v;
            end
        end
        m_ras_q <= ras_n; m_u_q <= ucas_n; m_l_q <= lcas_n;
    end
    assign dq_in = (!oe_n && !(ucas_n && lcas_n)) ? m_rdata : 16'h0;

    // ---------------- host side and shadow memory ----------------
    logic [15:0] smem [int];
    logic [15:0] rdq [$];
    logic [9:0]  exp_row = '0, exp_col = '0;
    logic        exp_wr = 0;
    logic [15:0] exp_data = '0;
    logic [1:0]  exp_be = '0;
    int reads_issued = 0, reads_seen = 0, accepted = 0, issued = 0;

    function automatic logic [15:0] sread(input int k);
        return smem.exists(k) ? smem[k] : 16'h0;
    endfunction

    // Issue one request at a falling edge and wait for acceptance (R13).
    task automatic issue(input bit wr, input logic [19:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        int w = 0;
        logic [15:0] v;
        issued++;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready && w < 3000) begin @(negedge clk); w++; end
        @(posedge clk);
        accepted++;
        exp_row = a[19:10]; exp_col = a[9:0]; exp_wr = wr; exp_data = d; exp_be = be;
        v = sread(int'(a));
        if (wr) begin
            if (be[1]) v[15:8] = d[15:8];
            if (be[0]) v[7:0]  = d[7:0];
            smem[int'(a)] = v;
        end else begin
            rdq.push_back(v);
            reads_issued++;
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    // ---------------- strobe monitors ----------------
    logic p_ras = 1, p_u = 1, p_l = 1, p_we = 1;
    int t_ras_fall = -100, t_ras_rise = 0, t_cas_fall = -100, t_cas_rise = -100;
    int ras_falls = 0;

    always @(negedge clk) begin
        logic cas_now, cas_prev;
        cyc++;
        if (rst_n) begin
            cas_now  = !(ucas_n && lcas_n);
            cas_prev = !(p_u && p_l);
            if (p_ras && !ras_n) begin
                chk(cyc - t_ras_rise >= T_RP, "R9 precharge", cyc - t_ras_rise, T_RP);
                chk(daddr == exp_row, "R2 row addr", daddr, exp_row);
                t_ras_fall = cyc;
                ras_falls++;
            end
            if (!p_ras && ras_n) begin
                chk(cyc - t_ras_fall >= T_RAS, "R9 ras low min", cyc - t_ras_fall, T_RAS);
                chk(cyc - t_ras_fall <= T_RAS_MAX, "R11 ras low max", cyc - t_ras_fall, T_RAS_MAX);
                t_ras_rise = cyc;
            end
            if (!cas_prev && cas_now) begin
                chk(!ras_n, "R2 cas inside ras", ras_n, 0);
                chk(daddr == exp_col, "R2 col addr", daddr, exp_col);
                chk(cyc - t_ras_fall >= T_RCD, "R8 ras to cas", cyc - t_ras_fall, T_RCD);
                if (t_cas_rise > t_ras_fall)
                    chk(cyc - t_cas_rise >= T_CP, "R10 cas precharge", cyc - t_cas_rise, T_CP);
                if (exp_wr) begin
                    chk({ucas_n, lcas_n} == ~exp_be, "R5 byte strobes", {ucas_n, lcas_n}, ~exp_be);
                    chk(!p_we && !we_n && dq_oe, "R4 early write", {p_we, we_n, dq_oe}, 3'b001);
                    chk((dq_out & {{8{exp_be[1]}}, {8{exp_be[0]}}}) ==
                        (exp_data & {{8{exp_be[1]}}, {8{exp_be[0]}}}), "R4 write data", dq_out, exp_data);
                end else begin
                    chk(!ucas_n && !lcas_n && we_n && !oe_n, "R3 read strobes",
                        {ucas_n, lcas_n, we_n, oe_n}, 4'b0010);
                end
                t_cas_fall = cyc;
            end
            if (cas_prev && !cas_now) begin
                chk(cyc - t_cas_fall >= T_CAS, "R10 cas width", cyc - t_cas_fall, T_CAS);
                t_cas_rise = cyc;
            end
            if (rd_valid) begin
                logic [15:0] e;
                e = (rdq.size() > 0) ? rdq.pop_front() : 16'hxxxx;
                reads_seen++;
                chk(cyc - t_cas_fall == RD_LAT, "R3 read latency", cyc - t_cas_fall, RD_LAT);
                chk(rd_data === e, "R3 read data", rd_data, e);
            end
            if (refresh_gnt)
                chk(ras_n && ucas_n && lcas_n && !dq_oe, "R12 grant quiet",
                    {ras_n, ucas_n, lcas_n, dq_oe}, 4'b1110);
        end
        p_ras = ras_n; p_u = ucas_n; p_l = lcas_n; p_we = we_n;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        bad++; checks++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int f0;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(ras_n && ucas_n && lcas_n && we_n && oe_n && !dq_oe, "R1 strobes in reset",
            {ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe}, 6'b111110);
        rst_n = 1;
        @(negedge clk);
        chk(ras_n && ucas_n && lcas_n && !dq_oe && !rd_valid && !refresh_gnt,
            "R1 after reset", {ras_n, ucas_n, lcas_n, dq_oe, rd_valid, refresh_gnt}, 6'b111000);

        // R6: four accesses to row 5 need a single activation.
        f0 = ras_falls;
        issue(1, {10'd5, 10'd1}, 16'hA1B2, 2'b11);
        issue(1, {10'd5, 10'd2}, 16'hC3D4, 2'b11);
        issue(0, {10'd5, 10'd1}, 16'h0, 2'b00);
        issue(0, {10'd5, 10'd2}, 16'h0, 2'b00);
        repeat (8) @(negedge clk);
        chk(ras_falls - f0 == 1, "R6 page hit no reactivation", ras_falls - f0, 1);

        // R5: single-byte writes leave the other byte alone.
        issue(1, {10'd5, 10'd1}, 16'h5500, 2'b10);
        issue(1, {10'd5, 10'd2}, 16'h0066, 2'b01);
        issue(0, {10'd5, 10'd1}, 16'h0, 2'b00);
        issue(0, {10'd5, 10'd2}, 16'h0, 2'b00);

        // R7: a miss reactivates; old row data kept.
        f0 = ras_falls;
        issue(1, {10'd9, 10'd3}, 16'h7788, 2'b11);
        issue(0, {10'd5, 10'd1}, 16'h0, 2'b00);
        repeat (8) @(negedge clk);
        chk(ras_falls - f0 == 2, "R7 miss reactivation", ras_falls - f0, 2);

        // R12: refresh while a row is open.
        issue(0, {10'd9, 10'd3}, 16'h0, 2'b00);
        repeat (10) @(negedge clk);
        refresh_req = 1;
        #1 chk(!req_ready, "R12 ready low in refresh", req_ready, 0);
        begin
            int w = 0;
            while (!refresh_gnt && w < 200) begin @(negedge clk); w++; end
        end
        chk(refresh_gnt, "R12 grant given", refresh_gnt, 1);
        repeat (5) @(negedge clk);
        chk(refresh_gnt && ras_n && !req_ready, "R12 grant held", {refresh_gnt, ras_n, req_ready}, 3'b110);
        refresh_req = 0;
        @(negedge clk);
        chk(!refresh_gnt, "R12 grant released", refresh_gnt, 0);
        issue(0, {10'd9, 10'd3}, 16'h0, 2'b00);

        // R11: a long stream of hits to one row must be split.
        f0 = ras_falls;
        for (int i = 0; i < 200; i++)
            issue($urandom_range(1, 0), {10'd12, 10'(i)}, 16'($urandom), 2'($urandom_range(3, 0)));
        repeat (8) @(negedge clk);
        chk(ras_falls - f0 > 1, "R11 forced close", ras_falls - f0, 2);

        // Random traffic over four rows and eight columns.
        for (int i = 0; i < 400; i++) begin
            logic [19:0] a;
            a = {8'd0, 2'($urandom_range(3, 0)), 7'd0, 3'($urandom_range(7, 0))};
            issue($urandom_range(1, 0), a, 16'($urandom), 2'($urandom_range(3, 0)));
        end
        repeat (20) @(negedge clk);
        chk(reads_seen == reads_issued, "R13 one result per read", reads_seen, reads_issued);
        chk(accepted == issued, "R13 all requests accepted", accepted, issued);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule